// File: doc/BRIEF.md
# Teletext Packet Event Flag Detector

This block watches the address header of every teletext packet that the slicer and byte framer hand it and raises two sticky status flags when particular packets go past. The first flag marks the arrival of the broadcast service data packet. The second flag marks the arrival of a fast-text link packet. Each flag stays up until software clears it. Software reads the flags from a two-bit output and clears them through a one-cycle write strobe with a two-bit data word.

Each packet is presented for one cycle with a valid strobe. The packet comes as four raw Hamming 8/4 protected bytes:

- the low address byte, which carries the magazine and the least significant row bit;
- the high address byte, which carries the upper four row bits;
- the extra address byte, which is used on 525-line services;
- the designation byte.

The block corrects single-bit errors in these bytes. It matches the decoded fields against the rules of the active line standard, which is selected by a mode input. A flag is set whether or not any other part of the chip stores that packet.

Top module: `pkt_flag_detect`

## Requirements
- R1: Each byte is decoded as Hamming 8/4. Data bits d0..d3 sit at byte bits 1, 3, 5 and 7. The protection bits are at bits 0, 2, 4 and 6, chosen so that four groups have odd parity: bits {0,1,5,7}, bits {1,2,3,7}, bits {1,3,4,5} and all eight bits. Any byte within one bit flip of a codeword decodes to that codeword's nibble.
- R2: A byte two bit flips from every codeword is uncorrectable. An uncorrectable low or high address byte discards the packet, so neither flag is set. An uncorrectable designation byte blocks the fast-text event. In 525-line mode, an uncorrectable extra address byte also blocks the fast-text event.
- R3: The magazine is low-byte nibble bits [2:0], where field value 0 means magazine 8. The row is {high nibble, low nibble bit 3}. With mode_525 low, a valid packet with magazine 8 and row 30 sets flags[0]. Row 30 in any other magazine does not.
- R4: With mode_525 high, a valid packet with magazine 4 and row 30 sets flags[0]. Magazine 8 row 30 does not.
- R5: With mode_525 low, a valid row 27 packet of any magazine whose designation nibble is 0 sets flags[1]. The extra address byte is ignored. Any other designation value, and any other row, leaves flags[1] clear.
- R6: With mode_525 high, a row 27 packet sets flags[1] only if both the designation nibble and the extra address nibble decode to 0.
- R7: A set flag holds until a write with sw_wr high carries 0 in that flag's bit position. A 1 in that position leaves the flag unchanged.
- R8: When a packet event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R9: Fields are evaluated only while pkt_valid is high. A flag set by a packet is visible on flags in the cycle after the strobe.
- R10: While rst_n is low, both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_valid | input | 1 | Packet header fields are valid this cycle |
| mode_525 | input | 1 | 1 selects 525-line matching rules, 0 selects 625-line rules |
| addr_lo_ham | input | 8 | Hamming coded magazine and row bit 0 |
| addr_hi_ham | input | 8 | Hamming coded row bits 4..1 |
| ext_ham | input | 8 | Hamming coded extra address field |
| desig_ham | input | 8 | Hamming coded designation code |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 2 | Write data; a 0 bit clears the matching flag |
| flags | output | 2 | Bit 0 is the broadcast service data flag, bit 1 is the fast-text flag |

## Verification
The bench runs each of the four coded byte inputs through all 256 values while the other three bytes carry clean codewords chosen so that exactly one event depends on the byte under test. This separates correct codewords, correctable single flips and uncorrectable double flips. It also separates an error in a field that blocks an event from an error in a field the rule ignores.

A second sweep runs every magazine and row combination in both line standards. This sweep tells the 8/30 and 4/30 triggers apart, checks that field value 0 is read as magazine 8, and checks the extra address condition that applies only in 525-line mode.

Directed sequences cover:
- stimulus without the strobe;
- the one-cycle latency;
- writes of 1 against writes of 0;
- a set that coincides with a clear.

// File: rtl/tt_flag_pkg.sv
// Shared widths, flag positions and decoded-field type for the teletext
// packet event flag detector. Assumes Hamming 8/4 protected nibbles.
package tt_flag_pkg;
    localparam int BYTE_W    = 8;
    localparam int NIB_W     = 4;
    localparam int MAG_W     = 3;
    localparam int ROW_W     = 5;
    localparam int NUM_FLAGS = 2;
    localparam int NUM_BYTES = 4;

    // Flag bit positions as seen by software
    localparam int FLAG_BSD  = 0;
    localparam int FLAG_FT   = 1;

    // Byte slots of the incoming header
    localparam int SLOT_LO   = 0;
    localparam int SLOT_HI   = 1;
    localparam int SLOT_EXT  = 2;
    localparam int SLOT_DES  = 3;

    // One decoded nibble plus its usability indication
    typedef struct packed {
        logic [NIB_W-1:0] data;
        logic             ok;
    } ham_res_t;
endpackage

// File: rtl/ham84_decode.sv
// Combinational Hamming 8/4 decoder.
// Data bits are at byte bits 1,3,5,7. Four odd-parity groups give a
// three-bit locator syndrome plus an overall check. A single flipped bit
// is corrected. A double flip is flagged as unusable.
module ham84_decode
    import tt_flag_pkg::*;
(
    input  logic [BYTE_W-1:0] code,
    output ham_res_t          res
);
    logic       grp_a, grp_b, grp_c, grp_all;
    logic [2:0] syn;
    logic [NIB_W-1:0] raw;
    logic [NIB_W-1:0] flip;

    // Parity groups: a group is good when its parity is odd
    always_comb begin
        grp_a   = ^{code[0], code[1], code[5], code[7]};
        grp_b   = ^{code[1], code[2], code[3], code[7]};
        grp_c   = ^{code[1], code[3], code[4], code[5]};
        grp_all = ^code;
        syn     = {~grp_c, ~grp_b, ~grp_a};
        raw     = {code[7], code[5], code[3], code[1]};
    end

    // Locate and correct a single error, or flag a double error
    always_comb begin
        flip = '0;
        if (grp_all) begin
            res.ok = (syn == 3'b000);
        end else begin
            res.ok = 1'b1;
            case (syn)
                3'b111:  flip[0] = 1'b1;
                3'b110:  flip[1] = 1'b1;
                3'b101:  flip[2] = 1'b1;
                3'b011:  flip[3] = 1'b1;
                default: flip    = '0;
            endcase
        end
        res.data = raw ^ flip;
    end
endmodule

// File: rtl/pkt_match.sv
// Matches decoded header fields against the trigger packets of the active
// line standard. Produces one-cycle event pulses, gated by the valid strobe.
// Assumes field value 0 in the magazine slot means magazine 8.
module pkt_match
    import tt_flag_pkg::*;
#(
    parameter int ROW_BSD     = 30,
    parameter int ROW_FT      = 27,
    parameter int MAG_BSD_625 = 8,
    parameter int MAG_BSD_525 = 4,
    parameter int DES_FT      = 0,
    parameter int EXT_FT_525  = 0
) (
    input  logic                 pkt_valid,
    input  logic                 mode_525,
    input  ham_res_t             lo,
    input  ham_res_t             hi,
    input  ham_res_t             ext,
    input  ham_res_t             des,
    output logic [NUM_FLAGS-1:0] hit
);
    localparam logic [ROW_W-1:0] ROW_BSD_V = ROW_W'(ROW_BSD);
    localparam logic [ROW_W-1:0] ROW_FT_V  = ROW_W'(ROW_FT);
    localparam logic [NIB_W-1:0] MAG625_V  = NIB_W'(MAG_BSD_625);
    localparam logic [NIB_W-1:0] MAG525_V  = NIB_W'(MAG_BSD_525);
    localparam logic [NIB_W-1:0] DES_V     = NIB_W'(DES_FT);
    localparam logic [NIB_W-1:0] EXT_V     = NIB_W'(EXT_FT_525);

    logic [MAG_W-1:0] mag_field;
    logic [NIB_W-1:0] mag_num;
    logic [ROW_W-1:0] row;
    logic             addr_ok;
    logic             bsd_mag;
    logic             ft_ext;

    // Field assembly and magazine renumbering
    always_comb begin
        mag_field = lo.data[MAG_W-1:0];
        mag_num   = (mag_field == '0) ? NIB_W'(8) : {1'b0, mag_field};
        row       = {hi.data, lo.data[NIB_W-1]};
        addr_ok   = lo.ok && hi.ok;
    end

    // Standard-dependent qualifiers
    always_comb begin
        bsd_mag = mode_525 ? (mag_num == MAG525_V) : (mag_num == MAG625_V);
        ft_ext  = !mode_525 || (ext.ok && ext.data == EXT_V);
    end

    // Event pulses
    always_comb begin
        hit           = '0;
        hit[FLAG_BSD] = pkt_valid && addr_ok && (row == ROW_BSD_V) && bsd_mag;
        hit[FLAG_FT]  = pkt_valid && addr_ok && (row == ROW_FT_V)
                        && des.ok && (des.data == DES_V) && ft_ext;
    end
endmodule

// File: rtl/sticky_flag.sv
// One software-clearable sticky status bit. A set wins over a clear that
// arrives in the same cycle.
module sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Set has priority, then clear, else hold
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= 1'b0;
        else if (set) q <= 1'b1;
        else if (clr) q <= 1'b0;
    end
endmodule

// File: rtl/pkt_flag_detect.sv
// Top of the teletext packet event flag detector.
// Decodes the four Hamming-coded header bytes, matches the trigger packets
// of the selected line standard and keeps one sticky flag per event.
// Assumes each header is presented for one cycle with pkt_valid.
module pkt_flag_detect
    import tt_flag_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_valid,
    input  logic                 mode_525,
    input  logic [BYTE_W-1:0]    addr_lo_ham,
    input  logic [BYTE_W-1:0]    addr_hi_ham,
    input  logic [BYTE_W-1:0]    ext_ham,
    input  logic [BYTE_W-1:0]    desig_ham,
    input  logic                 sw_wr,
    input  logic [NUM_FLAGS-1:0] sw_wdata,
    output logic [NUM_FLAGS-1:0] flags
);
    logic [BYTE_W-1:0]    code_arr [NUM_BYTES];
    ham_res_t             dec_arr  [NUM_BYTES];
    logic [NUM_FLAGS-1:0] hit_vec;

    // Gather the coded bytes into slot order
    always_comb begin
        code_arr[SLOT_LO]  = addr_lo_ham;
        code_arr[SLOT_HI]  = addr_hi_ham;
        code_arr[SLOT_EXT] = ext_ham;
        code_arr[SLOT_DES] = desig_ham;
    end

    for (genvar b = 0; b < NUM_BYTES; b++) begin : g_dec
        ham84_decode i_dec (
            .code (code_arr[b]),
            .res  (dec_arr[b])
        );
    end

    pkt_match i_match (
        .pkt_valid (pkt_valid),
        .mode_525  (mode_525),
        .lo        (dec_arr[SLOT_LO]),
        .hi        (dec_arr[SLOT_HI]),
        .ext       (dec_arr[SLOT_EXT]),
        .des       (dec_arr[SLOT_DES]),
        .hit       (hit_vec)
    );

    for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
        sticky_flag i_flag (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (hit_vec[f]),
            .clr   (sw_wr && !sw_wdata[f]),
            .q     (flags[f])
        );
    end
endmodule

// File: rtl/pkt_flag_detect_chk.sv
// Property checker for pkt_flag_detect, bound to every instance of it.
module pkt_flag_detect_chk
    import tt_flag_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 pkt_valid,
    input logic                 sw_wr,
    input logic [NUM_FLAGS-1:0] sw_wdata,
    input logic [NUM_FLAGS-1:0] hit,
    input logic [NUM_FLAGS-1:0] flags
);
    // R9: with no strobe and no write, the flags do not move
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pkt_valid && !sw_wr) |=> $stable(flags));

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_p
        // R8: a matching packet leaves its flag set, even against a clear
        p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> flags[i]);
        // R7: a set flag survives anything but a zero written to its bit
        p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(sw_wr && !sw_wdata[i])) |=> flags[i]);
        // R7: a zero written with no competing event clears the flag
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (sw_wr && !sw_wdata[i] && !hit[i]) |=> !flags[i]);
        // R9: a clear flag rises only through a packet event
        p_no_spont_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (!flags[i] && !hit[i]) |=> !flags[i]);
    end
endmodule

bind pkt_flag_detect pkt_flag_detect_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_valid (pkt_valid),
    .sw_wr     (sw_wr),
    .sw_wdata  (sw_wdata),
    .hit       (hit_vec),
    .flags     (flags)
);

// File: tb/test_pkt_flag_detect.sv
// Self-checking bench: sweeps every coded byte value and every
// magazine/row pair in both standards, plus directed sticky-flag sequences.
module test_pkt_flag_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pkt_valid = 1'b0;
    logic       mode_525 = 1'b0;
    logic [7:0] addr_lo_ham = 8'h00;
    logic [7:0] addr_hi_ham = 8'h00;
    logic [7:0] ext_ham = 8'h00;
    logic [7:0] desig_ham = 8'h00;
    logic       sw_wr = 1'b0;
    logic [1:0] sw_wdata = 2'b00;
    logic [1:0] flags;
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    pkt_flag_detect i_pkt_flag_detect (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .mode_525(mode_525),
        .addr_lo_ham(addr_lo_ham), .addr_hi_ham(addr_hi_ham),
        .ext_ham(ext_ham), .desig_ham(desig_ham),
        .sw_wr(sw_wr), .sw_wdata(sw_wdata), .flags(flags)
    );

    // Encoder built from the parity groups of R1
    function automatic logic [7:0] enc(input logic [3:0] d);
        logic p0, p1, p2, p3;
        p0 = ~(d[0] ^ d[2] ^ d[3]);
        p1 = ~(d[0] ^ d[1] ^ d[3]);
        p2 = ~(d[0] ^ d[1] ^ d[2]);
        p3 = ~(p0 ^ d[0] ^ p1 ^ d[1] ^ p2 ^ d[2] ^ d[3]);
        return {d[3], p3, d[2], p2, d[1], p1, d[0], p0};
    endfunction

    // Nearest-codeword search: usable when within one flip
    function automatic void dec(input logic [7:0] b, output logic [3:0] v,
                                output logic ok);
        ok = 1'b0;
        v  = 4'h0;
        for (int n = 0; n < 16; n++) begin
            if ($countones(b ^ enc(4'(n))) <= 1) begin
                ok = 1'b1;
                v  = 4'(n);
            end
        end
    endfunction

    function automatic logic [1:0] expect_flags(input logic [7:0] lo,
        input logic [7:0] hi, input logic [7:0] ex, input logic [7:0] de,
        input logic m525);
        logic [3:0] lv, hv, ev, dv;
        logic lok, hok, eok, dok;
        logic [4:0] row;
        int mag;
        logic [1:0] r;
        dec(lo, lv, lok);
        dec(hi, hv, hok);
        dec(ex, ev, eok);
        dec(de, dv, dok);
        row = {hv, lv[3]};
        mag = (lv[2:0] == 3'd0) ? 8 : int'(lv[2:0]);
        r = 2'b00;
        if (lok && hok) begin
            r[0] = (row == 5'd30) && (mag == (m525 ? 4 : 8));
            r[1] = (row == 5'd27) && dok && (dv == 4'd0)
                   && (!m525 || (eok && ev == 4'd0));
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [1:0] exp);
        n_cmp++;
        if (flags !== exp) begin
            n_bad++;
            $display("FAIL %s: flags=%b expected %b", req, flags, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        sw_wr = 1'b1;
        sw_wdata = 2'b00;
        @(negedge clk);
        sw_wr = 1'b0;
        check("R7 clear", 2'b00);
    endtask

    task automatic send(input logic [7:0] lo, input logic [7:0] hi,
                        input logic [7:0] ex, input logic [7:0] de,
                        input logic m525, input string req);
        @(negedge clk);
        addr_lo_ham = lo; addr_hi_ham = hi; ext_ham = ex; desig_ham = de;
        mode_525 = m525; pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        check(req, expect_flags(lo, hi, ex, de, m525));
        clear_all();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10 reset", 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset", 2'b00);

        // R9: matching fields without the strobe do nothing
        addr_lo_ham = enc(4'h0); addr_hi_ham = enc(4'hF);
        ext_ham = enc(4'h0); desig_ham = enc(4'h0); mode_525 = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 no strobe", 2'b00);
        // R9: one strobe, flag visible in the next cycle
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        check("R9 latency", 2'b01);
        // R5: add the fast-text flag
        addr_lo_ham = enc(4'h9); addr_hi_ham = enc(4'hD);
        pkt_valid = 1'b1;
        @(negedge clk);
        pkt_valid = 1'b0;
        check("R5 second flag", 2'b11);
        // R7: idle cycles and writes of 1 keep both flags
        repeat (3) @(negedge clk);
        check("R7 hold", 2'b11);
        sw_wr = 1'b1; sw_wdata = 2'b11;
        @(negedge clk);
        sw_wr = 1'b0;
        check("R7 write ones", 2'b11);
        // R7: zero in bit 0 only
        sw_wr = 1'b1; sw_wdata = 2'b10;
        @(negedge clk);
        sw_wr = 1'b0;
        check("R7 partial clear", 2'b10);
        // R8: broadcast data packet coincides with a clear of both flags
        addr_lo_ham = enc(4'h0); addr_hi_ham = enc(4'hF);
        pkt_valid = 1'b1; sw_wr = 1'b1; sw_wdata = 2'b00;
        @(negedge clk);
        pkt_valid = 1'b0; sw_wr = 1'b0;
        check("R8 set wins", 2'b01);
        clear_all();

        // R1 R2 R3: low address byte sweep (row 30/31, 625 mode)
        for (int b = 0; b < 256; b++)
            send(8'(b), enc(4'hF), enc(4'h0), enc(4'h0), 1'b0, "R1 R2 R3 lo sweep");
        // R1 R2: high address byte sweep
        for (int b = 0; b < 256; b++)
            send(enc(4'h0), 8'(b), enc(4'h0), enc(4'h0), 1'b0, "R1 R2 hi sweep");
        // R5 R2: designation sweep, 625 mode, extra byte nonzero and ignored
        for (int b = 0; b < 256; b++)
            send(enc(4'hB), enc(4'hD), enc(4'h5), 8'(b), 1'b0, "R5 R2 desig sweep");
        // R6 R2: extra address sweep, 525 mode
        for (int b = 0; b < 256; b++)
            send(enc(4'hB), enc(4'hD), 8'(b), enc(4'h0), 1'b1, "R6 R2 ext sweep");
        // R3 R4 R5 R6: every magazine and row in both standards
        for (int m = 0; m < 2; m++)
            for (int g = 0; g < 8; g++)
                for (int r = 0; r < 32; r++)
                    send(enc({r[0], g[2:0]}), enc(r[4:1]), enc(4'h0), enc(4'h0),
                         m[0], "R3 R4 R5 R6 address sweep");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule